// File: doc/BRIEF.md
# Escaped Packet Stream Framer

This block turns a packet, delivered one byte at a time over a valid/ready handshake with a last-byte flag, into the raw byte stream carried by a serial physical layer. Every packet opens with a start marker, a channel marker and the channel number. A data byte that collides with a reserved code is sent as a two-byte escape pair. When no packet byte is pending, the block offers an idle filler byte.

The physical layer decides when a byte leaves. It pulses `out_strobe` in every cycle where it takes the byte currently on `out_byte`. The framer advances only on that strobe. An input byte is accepted in the same cycle that its final output byte is taken, so `in_ready` is low while markers and escape prefixes go out.

The end marker is placed before the final data byte of the packet, not after it. A receiver therefore knows that the next data byte closes the packet.

Top module: `esc_framer`

## Requirements
- R1: After reset, and whenever no packet byte is pending (idle, or between packets), `out_byte` is the idle code 0x4A.
- R2: Each packet begins with the three output bytes 0x7A (start), 0x7C (channel marker) and the channel number (parameter `CHANNEL_ID`, default 0x00), in that order.
- R3: A data byte that is none of 0x4A, 0x4D, 0x7A, 0x7B, 0x7C or 0x7D is output unchanged, and data bytes keep their input order.
- R4: A data byte in the range 0x7A to 0x7D is output as 0x7D followed by the byte XOR 0x20.
- R5: A data byte of 0x4A or 0x4D is output as 0x4D followed by the byte XOR 0x20.
- R6: The end marker 0x7B is output once per packet, immediately before the output bytes of the last data byte. When the last data byte needs escaping, 0x7B comes before its escape prefix.
- R7: `in_ready` is high only in a cycle where `out_strobe` is high and the byte being taken is the last output byte of the current input byte. It is low while start, channel, end or escape prefix bytes are output.
- R8: The output moves on only at an `out_strobe`. With no strobe and steady inputs, `out_byte` holds its value, and each byte of the framed stream is taken exactly once.
- R9: If `in_valid` drops in the middle of a packet, the idle code 0x4A is output until the next data byte arrives, and the packet then continues without new markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Packet data byte |
| in_last | input | 1 | Marks the final data byte of a packet |
| in_valid | input | 1 | `in_data` and `in_last` are valid |
| in_ready | output | 1 | The input byte is consumed at this clock edge |
| out_strobe | input | 1 | The physical layer takes `out_byte` at this edge |
| out_byte | output | 8 | Byte offered to the physical layer |

## Verification
The bound checker tests the following on every cycle:
- a start marker is always followed by the channel marker, and the channel marker by the channel number;
- every escape prefix is followed by a folded value of the matching class;
- the end marker is followed by the packet's last byte;
- `in_ready` rises only with a strobe, and an accepted byte appears raw or folded;
- the output holds while no strobe arrives;
- the stream returns to idle after a last byte.

Whole-stream order, the count of emitted bytes and the coverage of the reserved codes can only be shown by the bench's scoreboard. The bench runs packets under full-rate, sparse and stalled strobes, with input gaps and with escaped final bytes.

// File: rtl/esc_framer_pkg.sv
package esc_framer_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] K_START   = 8'h7A;
    localparam logic [BYTE_W-1:0] K_END     = 8'h7B;
    localparam logic [BYTE_W-1:0] K_CHMARK  = 8'h7C;
    localparam logic [BYTE_W-1:0] K_PKT_ESC = 8'h7D;
    localparam logic [BYTE_W-1:0] K_IDLE    = 8'h4A;
    localparam logic [BYTE_W-1:0] K_PHY_ESC = 8'h4D;
    localparam logic [BYTE_W-1:0] K_FOLD    = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHMARK,
        ST_CHNUM,
        ST_BODY,
        ST_FOLDED
    } fr_state_e;

    typedef struct packed {
        logic              esc;
        logic [BYTE_W-1:0] prefix;
        logic [BYTE_W-1:0] folded;
    } esc_info_t;

    function automatic esc_info_t classify(input logic [BYTE_W-1:0] b);
        esc_info_t r;
        r.folded = b ^ K_FOLD;
        r.esc    = 1'b0;
        r.prefix = K_PKT_ESC;
        if (b == K_START || b == K_END || b == K_CHMARK || b == K_PKT_ESC) begin
            r.esc    = 1'b1;
            r.prefix = K_PKT_ESC;
        end else if (b == K_IDLE || b == K_PHY_ESC) begin
            r.esc    = 1'b1;
            r.prefix = K_PHY_ESC;
        end
        return r;
    endfunction

endpackage

// File: rtl/esc_classify.sv
module esc_classify
    import esc_framer_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output esc_info_t         info
);
    always_comb info = classify(byte_in);
endmodule

// File: rtl/esc_framer_fsm.sv
module esc_framer_fsm
    import esc_framer_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CHANNEL_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    input  esc_info_t         info,
    input  logic              out_strobe,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_byte
);
    fr_state_e state_q, state_d;
    logic      end_sent_q, end_sent_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            end_sent_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            end_sent_q <= end_sent_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        end_sent_d = end_sent_q;
        out_byte   = K_IDLE;
        in_ready   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    out_byte = K_START;
                    if (out_strobe) state_d = ST_CHMARK;
                end
            end
            ST_CHMARK: begin
                out_byte = K_CHMARK;
                if (out_strobe) state_d = ST_CHNUM;
            end
            ST_CHNUM: begin
                out_byte = CHANNEL_ID;
                if (out_strobe) state_d = ST_BODY;
            end
            ST_BODY: begin
                if (in_valid) begin
                    if (in_last && !end_sent_q) begin
                        out_byte = K_END;
                        if (out_strobe) end_sent_d = 1'b1;
                    end else if (info.esc) begin
                        out_byte = info.prefix;
                        if (out_strobe) state_d = ST_FOLDED;
                    end else begin
                        out_byte = in_data;
                        in_ready = out_strobe;
                        if (out_strobe && in_last) begin
                            state_d    = ST_IDLE;
                            end_sent_d = 1'b0;
                        end
                    end
                end
            end
            ST_FOLDED: begin
                out_byte = info.folded;
                in_ready = out_strobe;
                if (out_strobe) begin
                    state_d = in_last ? ST_IDLE : ST_BODY;
                    if (in_last) end_sent_d = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/esc_framer.sv
module esc_framer
    import esc_framer_pkg::*;
#(
    parameter logic [7:0] CHANNEL_ID = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       out_strobe,
    output logic [7:0] out_byte
);
    esc_info_t info;

    esc_classify u_cls (
        .byte_in (in_data),
        .info    (info)
    );

    esc_framer_fsm #(.CHANNEL_ID(CHANNEL_ID)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_valid   (in_valid),
        .info       (info),
        .out_strobe (out_strobe),
        .in_ready   (in_ready),
        .out_byte   (out_byte)
    );
endmodule

// File: rtl/esc_framer_chk.sv
module esc_framer_chk #(
    parameter logic [7:0] CHANNEL_ID = 8'h00
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_data,
    input logic       in_last,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_strobe,
    input logic [7:0] out_byte
);
    p_idle_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_last |=> (!in_valid -> out_byte == 8'h4A));

    p_start_then_mark_r2: assert property (@(posedge clk) disable iff (rst)
        out_strobe && out_byte == 8'h7A |=> out_byte == 8'h7C);

    p_mark_then_chan_r2: assert property (@(posedge clk) disable iff (rst)
        out_strobe && out_byte == 8'h7C |=> out_byte == CHANNEL_ID);

    p_accept_data_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> (out_byte == in_data || out_byte == (in_data ^ 8'h20)));

    p_pkt_escape_pair_r4: assert property (@(posedge clk) disable iff (rst)
        out_strobe && out_byte == 8'h7D |=>
            (out_byte == 8'h5A || out_byte == 8'h5B || out_byte == 8'h5C || out_byte == 8'h5D));

    p_phy_escape_pair_r5: assert property (@(posedge clk) disable iff (rst)
        out_strobe && out_byte == 8'h4D |=> (out_byte == 8'h6A || out_byte == 8'h6D));

    p_end_before_last_r6: assert property (@(posedge clk) disable iff (rst)
        out_strobe && out_byte == 8'h7B |=> in_valid && in_last);

    p_ready_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_strobe);

    p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!out_strobe) && $stable(in_valid) && $stable(in_data) && $stable(in_last)
            |-> $stable(out_byte));
endmodule

bind esc_framer esc_framer_chk #(.CHANNEL_ID(CHANNEL_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_strobe (out_strobe),
    .out_byte   (out_byte)
);

// File: tb/esc_framer_bench.sv
module esc_framer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       out_strobe = 1'b0;
    logic [7:0] out_byte;

    int total = 0;
    int bad = 0;
    int strobe_mode = 1;
    int strobe_cnt = 0;
    logic [7:0] pkt [16];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    esc_framer u_esc_framer (
        .clk(clk), .rst(rst), .in_data(in_data), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_strobe(out_strobe), .out_byte(out_byte)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    // strobe generator: 0 off, 1 full rate, 2 every other cycle, 3 sparse random
    initial forever begin
        @(negedge clk);
        strobe_cnt++;
        case (strobe_mode)
            0: out_strobe = 1'b0;
            1: out_strobe = 1'b1;
            2: out_strobe = strobe_cnt[0];
            default: out_strobe = ($urandom % 3) != 0;
        endcase
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        #1;
        if (!rst && out_strobe) begin
            if (out_byte == 8'h4A) begin
                // idle filler, nothing pending from the packet side
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R1 stray byte", out_byte, 8'h4A);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_byte == e, t, out_byte, e);
            end
        end
    end

    task automatic send(input int len, input int gap_at);
        push(8'h7A, "R2 start");
        push(8'h7C, "R2 chmark");
        push(8'h00, "R2 chnum");
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = pkt[i];
            if (i == len - 1) push(8'h7B, "R6 end marker");
            if (b >= 8'h7A && b <= 8'h7D) begin
                push(8'h7D, "R4 prefix");
                push(b ^ 8'h20, "R4 folded");
            end else if (b == 8'h4A || b == 8'h4D) begin
                push(8'h4D, "R5 prefix");
                push(b ^ 8'h20, "R5 folded");
            end else begin
                push(b, "R3 data");
            end
        end
        for (int i = 0; i < len; i++) begin
            bit done;
            @(negedge clk);
            if (i == gap_at) begin
                in_valid = 1'b0;
                for (int g = 0; g < 3; g++) begin
                    #1;
                    check(out_byte == 8'h4A, "R9 gap idle", out_byte, 8'h4A);
                    @(negedge clk);
                end
            end
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_last  = (i == len - 1);
            done = 1'b0;
            while (!done) begin
                #1;
                if (in_ready) begin
                    done = 1'b1;
                    check(out_strobe == 1'b1, "R7 ready with strobe", out_strobe, 1);
                end else begin
                    @(negedge clk);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        #1;
        check(out_byte == 8'h4A, "R1 idle after packet", out_byte, 8'h4A);
        check(in_ready == 1'b0, "R7 no ready when idle", in_ready, 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_byte == 8'h4A, "R1 reset idle", out_byte, 8'h4A);
        check(in_ready == 1'b0, "R7 reset ready", in_ready, 0);
        rst = 1'b0;

        // plain data, full-rate strobe
        pkt[0] = 8'h01; pkt[1] = 8'h02; pkt[2] = 8'h03;
        send(3, -1);
        drain();

        // every reserved code, sparse strobe
        strobe_mode = 3;
        pkt[0] = 8'h7A; pkt[1] = 8'h7B; pkt[2] = 8'h7C; pkt[3] = 8'h7D;
        pkt[4] = 8'h4A; pkt[5] = 8'h4D; pkt[6] = 8'h11;
        send(7, -1);
        drain();

        // escaped last byte: end marker must precede its prefix (R6)
        strobe_mode = 2;
        pkt[0] = 8'h55; pkt[1] = 8'h7D;
        send(2, -1);
        drain();

        // single-byte packet that is the idle code
        strobe_mode = 1;
        pkt[0] = 8'h4A;
        send(1, -1);
        drain();

        // input gap mid-packet (R9)
        pkt[0] = 8'hA0; pkt[1] = 8'h7B; pkt[2] = 8'hA2; pkt[3] = 8'hA3;
        send(4, 2);
        drain();

        // stalled strobe: output holds the start marker (R8)
        strobe_mode = 0;
        pkt[0] = 8'h33; pkt[1] = 8'h4D;
        fork
            send(2, -1);
            begin
                @(negedge clk);
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    #1;
                    check(out_byte == 8'h7A, "R8 hold start", out_byte, 8'h7A);
                    check(in_ready == 1'b0, "R8 no ready stalled", in_ready, 0);
                end
                strobe_mode = 3;
            end
        join
        drain();

        // back-to-back packets
        strobe_mode = 1;
        pkt[0] = 8'hFE; pkt[1] = 8'h5A;
        send(2, -1);
        pkt[0] = 8'h6A;
        send(1, -1);
        drain();

        check(exp_q.size() == 0, "R8 all bytes once", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule